// File: doc/BRIEF.md
# Command Packet Header Dispatcher

This block sits beside the sequencer of a small command microcontroller and takes over the program counter when the firmware asks for its next command. The firmware retires a wait-for-input instruction. One instruction later, when the instruction in the delay slot after the wait retires, the dispatcher reads the command header currently held in general register 1 and works out what kind of packet it is. A register-write packet (top nibble 4'h4) always goes to one fixed handler, and the dispatcher writes register 1 back with its top four bits cleared. An opcode packet (top nibble 7'h7's nibble, 4'h7) goes to the handler named by its opcode field. In both cases the payload dword count is loaded into the remaining-count register, and the PC is redirected to the handler address read from a 128-entry jump table that software can write.

The interface to the sequencer is a per-instruction retire strobe with side flags. This is a control path that never stalls, so it has no valid/ready handshake and no back-pressure: every retired instruction is accepted in the cycle it is presented. All results are registered and appear in the cycle after the retiring step. A malformed header or a misplaced wait raises a fault flag. The flag stays high until reset and freezes all PC redirection.

Top module: `pkt_dispatch`

## Requirements
- R1: After reset, redir_valid, rem_we, r1_we and fault are all 0.
- R2: A retired wait (step_valid=1, step_wait=1, step_in_slot=0) produces no redirect and no count load by itself. The dispatch results appear one cycle after the next retired step, which is the delay-slot step.
- R3: If the header's bits[31:28] are 4'h4, the handler id is 127 and rem_val = bits[6:0]. The block sets r1_we=1 with r1_val equal to the header with bits[31:28] cleared.
- R4: If the header's bits[31:28] are 4'h7, the handler id is bits[22:16] and rem_val = bits[13:0]. Register 1 is not written (r1_we=0).
- R5: On a dispatch, redir_pc is the jump-table entry at the handler id. An entry written through jt_wr_en/jt_wr_idx/jt_wr_pc applies to every dispatch in a later cycle.
- R6: When a branch is pending (br_valid=1) on the delay-slot step, the dispatch target replaces it.
- R7: A retired step that does not dispatch and has br_valid=1 gives redir_valid=1 and redir_pc=br_target in the next cycle, with rem_we=0.
- R8: A delay-slot header whose bits[31:28] are neither 4'h4 nor 4'h7 sets fault. That step produces no redirect, no count load and no register-1 write.
- R9: A wait retired with step_in_slot=1 sets fault and does not arm a dispatch.
- R10: Once fault is set it stays 1 until reset. While it is set, the block asserts no redirect and no count load.
- R11: Cycles with step_valid=0 between the wait and the delay-slot step do not dispatch. The header is sampled on the delay-slot step itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_valid | input | 1 | An instruction retires this cycle |
| step_wait | input | 1 | The retiring instruction is wait-for-input |
| step_in_slot | input | 1 | The retiring instruction sits in a branch delay slot |
| br_valid | input | 1 | A branch target resolves at this step |
| br_target | input | PC_W | That branch target |
| hdr | input | 32 | Current value of general register 1 |
| jt_wr_en | input | 1 | Jump-table write strobe |
| jt_wr_idx | input | 7 | Jump-table entry to write |
| jt_wr_pc | input | PC_W | Handler address to store |
| redir_valid | output | 1 | PC redirect this cycle |
| redir_pc | output | PC_W | New PC |
| rem_we | output | 1 | Load the remaining-count register |
| rem_val | output | 14 | Payload dword count |
| r1_we | output | 1 | Write general register 1 |
| r1_val | output | 32 | Header with type field stripped |
| fault | output | 1 | Sticky fatal fault |

## Verification
The hardest case to reach is a delay-slot step that must dispatch and resolve a branch at the same time, with idle cycles before it. The header on the ports keeps changing during those idle cycles, so only the value present on the delay-slot step may be used. The bench covers this by sweeping all 128 opcodes with a pending branch on alternate ones and by inserting bubbles that carry decoy headers. It also forces the fault paths. It then resets and confirms that a malformed header and a wait in a delay slot each latch the fault and suppress every later redirect.

// File: rtl/pkt_dispatch_pkg.sv
package pkt_dispatch_pkg;
  localparam int HDR_W    = 32;
  localparam int ID_W     = 7;
  localparam int CNT_W    = 14;
  localparam int RW_CNT_W = 7;
  localparam int OP_LO    = 16;
  localparam logic [3:0] NIB_REGW = 4'h4;
  localparam logic [3:0] NIB_OPC  = 4'h7;

  typedef enum logic [1:0] {HK_BAD, HK_REGW, HK_OPC} hdr_kind_t;

  typedef struct packed {
    hdr_kind_t         kind;
    logic [ID_W-1:0]   id;
    logic [CNT_W-1:0]  cnt;
  } hdr_info_t;
endpackage

// File: rtl/pkt_hdr_decode.sv
module pkt_hdr_decode
  import pkt_dispatch_pkg::*;
#(
  parameter int REGW_ID = 127
) (
  input  logic [HDR_W-1:0] hdr,
  output hdr_info_t        info
);
  logic [3:0] nib;
  assign nib = hdr[HDR_W-1 -: 4];

  always_comb begin
    info = '{kind: HK_BAD, id: '0, cnt: '0};
    if (nib == NIB_REGW) begin
      info.kind = HK_REGW;
      info.id   = ID_W'(REGW_ID);
      info.cnt  = CNT_W'(hdr[RW_CNT_W-1:0]);
    end else if (nib == NIB_OPC) begin
      info.kind = HK_OPC;
      info.id   = hdr[OP_LO +: ID_W];
      info.cnt  = hdr[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/pkt_jump_table.sv
module pkt_jump_table
  import pkt_dispatch_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int PC_W  = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [ID_W-1:0] wr_idx,
  input  logic [PC_W-1:0] wr_pc,
  input  logic [ID_W-1:0] rd_idx,
  output logic [PC_W-1:0] rd_pc,
  output logic            rd_hit
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [PC_W-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                                mem[e] <= '0;
      else if (wr_en && wr_idx == ID_W'(e))      mem[e] <= wr_pc;
    end
  end

  assign rd_hit = (32'(rd_idx) < DEPTH);
  assign rd_pc  = rd_hit ? mem[rd_idx[IDX_W-1:0]] : '0;
endmodule

// File: rtl/pkt_dispatch_ctrl.sv
module pkt_dispatch_ctrl
  import pkt_dispatch_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             step_wait,
  input  logic             step_in_slot,
  input  logic             br_valid,
  input  logic [PC_W-1:0]  br_target,
  input  logic [HDR_W-1:0] hdr,
  input  hdr_info_t        info,
  input  logic [PC_W-1:0]  tbl_pc,
  input  logic             tbl_hit,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic             rem_we,
  output logic [CNT_W-1:0] rem_val,
  output logic             r1_we,
  output logic [HDR_W-1:0] r1_val,
  output logic             fault
);
  logic armed;
  logic arm_now, slot_step, wait_misplaced, hdr_ok, disp_ok, disp_bad, trip;

  assign arm_now        = step_valid && step_wait && !step_in_slot && !armed && !fault;
  assign slot_step      = step_valid && armed;
  assign wait_misplaced = step_valid && step_wait && step_in_slot;
  assign hdr_ok         = (info.kind != HK_BAD) && tbl_hit;
  assign disp_ok        = slot_step && hdr_ok && !fault;
  assign disp_bad       = slot_step && !hdr_ok;
  assign trip           = disp_bad || wait_misplaced;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      fault <= 1'b0;
    end else begin
      if (trip) fault <= 1'b1;
      if (trip || fault || slot_step) armed <= 1'b0;
      else if (arm_now)               armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      redir_valid <= 1'b0;
      redir_pc    <= '0;
      rem_we      <= 1'b0;
      rem_val     <= '0;
      r1_we       <= 1'b0;
      r1_val      <= '0;
    end else begin
      redir_valid <= disp_ok || (step_valid && br_valid && !trip && !fault);
      redir_pc    <= disp_ok ? tbl_pc : (br_valid ? br_target : '0);
      rem_we      <= disp_ok;
      rem_val     <= disp_ok ? info.cnt : '0;
      r1_we       <= disp_ok && (info.kind == HK_REGW);
      r1_val      <= (disp_ok && info.kind == HK_REGW) ? {4'h0, hdr[HDR_W-5:0]} : '0;
    end
  end

  // R10
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault);
  // R10
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> (!redir_valid && !rem_we));
  // R2
  load_has_redir_chk: assert property (@(posedge clk) disable iff (!rst_n) rem_we |-> redir_valid);
  // R3
  r1_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    r1_we |-> (rem_we && r1_val[HDR_W-1 -: 4] == 4'h0));
  // R9
  misplaced_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wait_misplaced |=> fault);
endmodule

// File: rtl/pkt_dispatch.sv
module pkt_dispatch
  import pkt_dispatch_pkg::*;
#(
  parameter int PC_W    = 12,
  parameter int DEPTH   = 128,
  parameter int REGW_ID = 127
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_valid,
  input  logic             step_wait,
  input  logic             step_in_slot,
  input  logic             br_valid,
  input  logic [PC_W-1:0]  br_target,
  input  logic [HDR_W-1:0] hdr,
  input  logic             jt_wr_en,
  input  logic [ID_W-1:0]  jt_wr_idx,
  input  logic [PC_W-1:0]  jt_wr_pc,
  output logic             redir_valid,
  output logic [PC_W-1:0]  redir_pc,
  output logic             rem_we,
  output logic [CNT_W-1:0] rem_val,
  output logic             r1_we,
  output logic [HDR_W-1:0] r1_val,
  output logic             fault
);
  hdr_info_t       info;
  logic [PC_W-1:0] tbl_pc;
  logic            tbl_hit;

  pkt_hdr_decode #(.REGW_ID(REGW_ID)) u_dec (.hdr(hdr), .info(info));

  pkt_jump_table #(.DEPTH(DEPTH), .PC_W(PC_W)) u_tbl (
    .clk(clk), .rst_n(rst_n), .wr_en(jt_wr_en), .wr_idx(jt_wr_idx),
    .wr_pc(jt_wr_pc), .rd_idx(info.id), .rd_pc(tbl_pc), .rd_hit(tbl_hit)
  );

  pkt_dispatch_ctrl #(.PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .step_wait(step_wait),
    .step_in_slot(step_in_slot), .br_valid(br_valid), .br_target(br_target),
    .hdr(hdr), .info(info), .tbl_pc(tbl_pc), .tbl_hit(tbl_hit),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .rem_we(rem_we),
    .rem_val(rem_val), .r1_we(r1_we), .r1_val(r1_val), .fault(fault)
  );
endmodule

// File: tb/pkt_dispatch_test.sv
module pkt_dispatch_test;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_valid = 0, step_wait = 0, step_in_slot = 0, br_valid = 0;
  logic [11:0] br_target = '0;
  logic [31:0] hdr = '0;
  logic        jt_wr_en = 0;
  logic [6:0]  jt_wr_idx = '0;
  logic [11:0] jt_wr_pc = '0;
  logic        redir_valid, rem_we, r1_we, fault;
  logic [11:0] redir_pc;
  logic [13:0] rem_val;
  logic [31:0] r1_val;

  int checks = 0, errors = 0;
  bit done = 0;

  pkt_dispatch uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] tbl_val(int i);
    return 12'((i * 37 + 5) % 4096);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, bit s, bit bv, logic [11:0] bt, logic [31:0] h);
    @(negedge clk);
    step_valid = v; step_wait = w; step_in_slot = s;
    br_valid = bv; br_target = bt; hdr = h;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; step_valid = 0; step_wait = 0; step_in_slot = 0; br_valid = 0;
    @(posedge clk); @(posedge clk); #1;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic jt_write(int i, logic [11:0] pc);
    @(negedge clk);
    jt_wr_en = 1; jt_wr_idx = 7'(i); jt_wr_pc = pc;
    @(negedge clk);
    jt_wr_en = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 redir_valid", 32'(redir_valid), 0);
    check("R1 rem_we", 32'(rem_we), 0);
    check("R1 r1_we", 32'(r1_we), 0);
    check("R1 fault", 32'(fault), 0);

    for (int i = 0; i < 128; i++) jt_write(i, tbl_val(i));

    // R4, R5, R6, R2: full opcode sweep, pending branch on odd opcodes
    for (int op = 0; op < 128; op++) begin
      logic [13:0] c;
      logic [31:0] h;
      c = 14'((op * 129 + 7) % 16384);
      h = {4'h7, 5'(op * 3), 7'(op), 2'(op), c};
      step(1, 1, 0, 0, '0, 32'h2000_0000);
      check("R2 no redirect on wait", 32'(redir_valid | rem_we), 0);
      step(1, 0, 0, op[0], 12'hABC, h);
      check("R6 R5 redir_valid", 32'(redir_valid), 1);
      check("R5 redir_pc", 32'(redir_pc), 32'(tbl_val(op)));
      check("R4 rem_we", 32'(rem_we), 1);
      check("R4 rem_val", 32'(rem_val), 32'(c));
      check("R4 r1_we", 32'(r1_we), 0);
    end

    // R3: register-write sweep over all counts
    for (int c = 0; c < 128; c++) begin
      logic [31:0] h;
      h = {4'h4, 7'(c * 5), 14'(c * 301), 7'(c)};
      step(1, 1, 0, 0, '0, 32'h0);
      step(1, 0, 0, 0, '0, h);
      check("R3 redir_pc", 32'(redir_pc), 32'(tbl_val(127)));
      check("R3 rem_val", 32'(rem_val), c);
      check("R3 r1_we", 32'(r1_we), 1);
      check("R3 r1_val", r1_val, h & 32'h0FFF_FFFF);
    end

    // R7: plain branch pass-through
    step(1, 0, 0, 1, 12'h5A5, 32'h7000_0001);
    check("R7 redir_valid", 32'(redir_valid), 1);
    check("R7 redir_pc", 32'(redir_pc), 32'h5A5);
    check("R7 rem_we", 32'(rem_we), 0);
    step(0, 0, 0, 0, '0, 0);
    check("R7 idle no redirect", 32'(redir_valid), 0);

    // R11: bubbles with decoy headers between wait and slot
    step(1, 1, 0, 0, '0, 0);
    for (int b = 0; b < 3; b++) begin
      step(0, 0, 0, 0, '0, {4'h7, 5'd0, 7'(b + 1), 2'd0, 14'd99});
      check("R11 bubble no dispatch", 32'(redir_valid | rem_we), 0);
    end
    step(1, 0, 0, 0, '0, {4'h7, 5'd0, 7'd9, 2'd0, 14'd3});
    check("R11 pc", 32'(redir_pc), 32'(tbl_val(9)));
    check("R11 count", 32'(rem_val), 3);

    // R5: table rewrite applies to later dispatch
    jt_write(9, 12'h123);
    step(1, 1, 0, 0, '0, 0);
    step(1, 0, 0, 0, '0, {4'h7, 5'd0, 7'd9, 2'd0, 14'd1});
    check("R5 rewritten entry", 32'(redir_pc), 32'h123);

    // R8, R10: bad header type
    step(1, 1, 0, 0, '0, 0);
    step(1, 0, 0, 1, 12'h777, 32'h2000_0005);
    check("R8 fault", 32'(fault), 1);
    check("R8 no redirect", 32'(redir_valid), 0);
    check("R8 no count load", 32'(rem_we | r1_we), 0);
    step(1, 1, 0, 0, '0, 0);
    step(1, 0, 0, 1, 12'h111, {4'h7, 5'd0, 7'd2, 2'd0, 14'd4});
    check("R10 no dispatch after fault", 32'(redir_valid | rem_we), 0);
    check("R10 fault sticky", 32'(fault), 1);

    do_reset();
    check("R1 fault cleared", 32'(fault), 0);

    // R9: wait in delay slot
    step(1, 1, 1, 0, '0, 0);
    check("R9 fault", 32'(fault), 1);
    step(1, 0, 0, 0, '0, {4'h7, 5'd0, 7'd2, 2'd0, 14'd4});
    check("R9 no dispatch", 32'(rem_we), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule